// File: doc/BRIEF.md
# Mode-Banked Register File

A sixteen-entry, 32-bit register file for a small processor core. It has two combinational read ports and one write port. The logical index of a register maps to a physical copy that depends on the current processor mode. Indices 0 to 7 always reach one shared set. The fast-interrupt mode has its own copies of indices 8 to 14. The interrupt mode and the supervisor mode each have their own copies of the stack pointer (index 13) and the link register (index 14). All other indices reach the user copies.

Index 15 is the program counter and status word. A 24-bit word counter sits in bits 25:2, so the byte address space is 26 bits and the two low address bits are always zero. Six status bits sit above the counter, and the current mode sits in bits 1:0. The core pulses `pc_step` after each fetch to advance the counter by one word. A branch-with-link pulses `link_en`, which copies the whole R15 word into the link register of the current mode. Sequencing of exception entry, decoding of mode changes and memory access are handled outside this block. The block only stores the mode it is given through `mode_we`/`mode_d`.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register copy reads 0, the counter is 0 and the mode is supervisor (3), so R15 reads 32'h0000_0003.
- R2: Mode encoding is 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor. Indices 0 to 7 reach the same registers in every mode.
- R3: In mode 1, indices 8 to 14 reach private copies, and the user copies are left unchanged by writes made there.
- R4: Modes 2 and 3 each reach private copies of indices 13 and 14. Indices 8 to 12 in those modes reach the user copies.
- R5: Reading index 15 returns status in bits 31:26, the word counter in bits 25:2 and the current mode in bits 1:0. `pc_addr` gives the counter as a byte address with bits 1:0 zero.
- R6: A `pc_step` pulse advances the counter by one word. The counter wraps from byte address 26'h3FF_FFFC to 0.
- R7: A write to index 15 loads the counter from data bits 25:2. It loads status from bits 31:26 only when `st_we` is high. Data bits 1:0 are ignored. In the same cycle, the write takes precedence over `pc_step`.
- R8: A `link_en` pulse stores the current R15 word into index 14 of the current mode. A port write to index 14 in the same cycle takes precedence.
- R9: `mode_we` loads `mode_d`. The new mapping applies from the next cycle. Reads and writes in the loading cycle still use the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load a new mode |
| mode_d | input | 2 | Mode to load |
| ra_idx | input | 4 | Read port A index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B index |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| st_we | input | 1 | Allow status bits to be written on an R15 write |
| pc_step | input | 1 | Advance counter one word |
| link_en | input | 1 | Copy R15 into the current link register |
| pc_addr | output | 26 | Counter as byte address |
| cur_mode | output | 2 | Current mode |

## Verification
A wrong bank mapping stays hidden until a register is read back in another mode. It then shows as a stale or foreign value on a read port one cycle after the mode change. For this reason the tests write distinct values in one mode and read them back across all four modes. Counter and status faults show on `pc_addr` and on an R15 read in the cycle right after the edge that caused them. The tests also drive the two same-cycle priority cases, write against step and write against link, directly.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW   = 32,
  parameter int PCW  = 24,
  parameter int NIDX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [1:0]    mode_d,
  input  logic [3:0]    ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          st_we,
  input  logic          pc_step,
  input  logic          link_en,
  output logic [PCW+1:0] pc_addr,
  output logic [1:0]    cur_mode
);
  localparam int STW  = DW - PCW - 2;
  localparam int NPHY = (NIDX - 1) + 7 + 2 + 2;
  localparam logic [3:0] PCI = 4'd15;
  localparam logic [3:0] LRI = 4'd14;

  logic [DW-1:0]  bank [0:NPHY-1];
  logic [PCW-1:0] pc;
  logic [STW-1:0] status;
  logic [1:0]     mode;
  logic [DW-1:0]  r15w;
  logic [4:0]     wp, lp;
  logic           pc_wr;

  function automatic logic [4:0] phys(input logic [1:0] m, input logic [3:0] i);
    phys = {1'b0, i};
    if (m == 2'b01 && i >= 4'd8 && i <= 4'd14)       phys = 5'(i) + 5'd7;
    else if (m == 2'b10 && i >= 4'd13 && i <= 4'd14) phys = 5'(i) + 5'd9;
    else if (m == 2'b11 && i >= 4'd13 && i <= 4'd14) phys = 5'(i) + 5'd11;
  endfunction

  assign r15w     = {status, pc, mode};
  assign wp       = phys(mode, wr_idx);
  assign lp       = phys(mode, LRI);
  assign pc_wr    = wr_en && wr_idx == PCI;
  assign ra_data  = (ra_idx == PCI) ? r15w : bank[phys(mode, ra_idx)];
  assign rb_data  = (rb_idx == PCI) ? r15w : bank[phys(mode, rb_idx)];
  assign pc_addr  = {pc, 2'b00};
  assign cur_mode = mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHY; k++) bank[k] <= '0;
      pc     <= '0;
      status <= '0;
      mode   <= 2'b11;
    end else begin
      if (link_en) bank[lp] <= r15w;
      if (wr_en && !pc_wr) bank[wp] <= wr_data;
      if (pc_wr) begin
        pc <= wr_data[PCW+1:2];
        if (st_we) status <= wr_data[DW-1 -: STW];
      end else if (pc_step) begin
        pc <= pc + 1'b1;
      end
      if (mode_we) mode <= mode_d;
    end
  end

  p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_step && !pc_wr) |=> pc_addr == $past(pc_addr) + 26'd4);

  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && !st_we) |=> $stable(status));

  p_pc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |=> pc_addr[PCW+1:2] == $past(wr_data[PCW+1:2]));

  p_link_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && !(wr_en && wr_idx == LRI)) |=> bank[$past(lp)] == $past(r15w));

  p_mode_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> cur_mode == $past(mode_d));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic clk = 0, rst_n = 0;
  logic mode_we = 0, wr_en = 0, st_we = 0, pc_step = 0, link_en = 0;
  logic [1:0] mode_d = 0;
  logic [3:0] ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic [31:0] wr_data = 0, ra_data, rb_data;
  logic [25:0] pc_addr;
  logic [1:0] cur_mode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  banked_regfile uut (.clk, .rst_n, .mode_we, .mode_d, .ra_idx, .ra_data, .rb_idx, .rb_data,
    .wr_en, .wr_idx, .wr_data, .st_we, .pc_step, .link_en, .pc_addr, .cur_mode);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    mode_we = 0; wr_en = 0; st_we = 0; pc_step = 0; link_en = 0;
  endtask

  task automatic wr(logic [3:0] i, logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; tick();
  endtask

  task automatic setm(logic [1:0] m);
    mode_we = 1; mode_d = m; tick();
  endtask

  task automatic rd(logic [3:0] i, output logic [31:0] v);
    ra_idx = i; #1; v = ra_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(15, v); chk("R1 r15", v, 32'h3);
    chk("R1 pc", 32'(pc_addr), 0);
    chk("R1 mode", 32'(cur_mode), 3);
    for (int i = 0; i < 15; i++) begin rd(4'(i), v); chk("R1 reg", v, 0); end
  endtask

  task automatic t_shared();
    logic [31:0] v;
    wr(5, 32'hA5A5_0005);
    for (int m = 0; m < 4; m++) begin
      setm(2'(m)); rd(5, v); chk("R2 shared r5", v, 32'hA5A5_0005);
    end
  endtask

  task automatic t_fiq();
    logic [31:0] v;
    setm(0);
    for (int i = 8; i < 15; i++) wr(4'(i), 32'(100 + i));
    setm(1);
    rd(12, v); chk("R3 fiq r12 private", v, 0);
    wr(8, 32'hF1F1_0008);
    rd(8, v); chk("R3 fiq r8", v, 32'hF1F1_0008);
    setm(0);
    rd(8, v); chk("R3 user r8 kept", v, 108);
  endtask

  task automatic t_irq_svc();
    logic [31:0] v;
    setm(2); wr(13, 32'h1111_0013); rd(10, v); chk("R4 irq r10 shared", v, 110);
    setm(3); wr(13, 32'h5555_0013); rd(12, v); chk("R4 svc r12 shared", v, 112);
    rd(13, v); chk("R4 svc r13", v, 32'h5555_0013);
    setm(2); rd(13, v); chk("R4 irq r13", v, 32'h1111_0013);
    setm(0); rd(13, v); chk("R4 user r13", v, 113);
  endtask

  task automatic t_pcinc();
    logic [31:0] v;
    for (int k = 0; k < 3; k++) begin pc_step = 1; tick(); end
    chk("R6 pc step", 32'(pc_addr), 12);
    rd(15, v); chk("R5 r15 layout", v, {6'd0, 24'd3, 2'b00});
  endtask

  task automatic t_r15wr();
    logic [31:0] v;
    wr(15, 32'hFFFF_FFFF);
    rd(15, v); chk("R7 pc-only write", v, {6'd0, 24'hFF_FFFF, 2'b00});
    chk("R5 pc_addr", 32'(pc_addr), 32'h3FF_FFFC);
    pc_step = 1; tick(); chk("R6 wrap", 32'(pc_addr), 0);
    st_we = 1; wr(15, 32'hA800_0013);
    rd(15, v); chk("R7 status write", v, {6'h2A, 24'd4, 2'b00});
    pc_step = 1; wr(15, 32'h0000_0020);
    chk("R7 write beats step", 32'(pc_addr), 32'h20);
    rd(15, v); chk("R7 status held", v[31:26], 6'h2A);
  endtask

  task automatic t_link();
    logic [31:0] v, r15;
    setm(3); rd(15, r15);
    link_en = 1; tick();
    rd(14, v); chk("R8 link svc r14", v, r15);
    setm(0); rd(14, v); chk("R8 user r14 kept", v, 114);
    link_en = 1; wr(14, 32'hBEEF_0014);
    rd(14, v); chk("R8 write beats link", v, 32'hBEEF_0014);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    setm(1);
    mode_we = 1; mode_d = 2; wr_en = 1; wr_idx = 9; wr_data = 32'hC0DE_0009; tick();
    chk("R9 mode loaded", 32'(cur_mode), 2);
    rd(9, v); chk("R9 old mode write r9 user", v, 109);
    setm(1); ra_idx = 9; rb_idx = 8; #1;
    chk("R9 porta fiq r9", ra_data, 32'hC0DE_0009);
    chk("R9 portb fiq r8", rb_data, 32'hF1F1_0008);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    t_reset(); t_shared(); t_fiq(); t_irq_svc(); t_pcinc(); t_r15wr(); t_link(); t_mode();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); errors++; checks++; $display("FAIL watchdog"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule